// File: doc/BRIEF.md
# Serial Burst Memory Access Port

This block is a serial-peripheral slave that gives an external host burst access to a 16-bit-addressed space of byte-wide on-chip memory. The host lowers chip select and sends a 16-bit start address, then an 8-bit command. The top command bit chooses the direction of the transfer. A read then shifts out one status byte taken from the local side, followed by memory bytes from consecutive addresses. A write takes in bytes from the host and stores each one at the next address. A burst has no length limit and ends when chip select rises.

The serial pins are brought into the system clock domain through two-stage synchronizers. The block therefore expects the serial clock to run several times slower than the system clock. The memory side is a single-cycle strobe interface, and read data returns one cycle after the read strobe. When a frame ends with a complete command, the command is copied into a register that the local processor can read, and a one-cycle interrupt is raised. The two commands whose low seven bits are all zero (0x80 and 0x00) do not update the register and raise no interrupt.

The engine is a state machine with these states:
- IDLE waits for chip select.
- ADDR_SHIFT collects the address.
- CMD_SHIFT collects the command.
- STATUS_OUT sends the status byte.
- READ_OUT streams read data.
- WRITE_IN collects write data.

The transitions are:
- start: IDLE to ADDR_SHIFT, when chip select is low.
- addr_done: ADDR_SHIFT to CMD_SHIFT, on the 16th rising edge.
- cmd_read: CMD_SHIFT to STATUS_OUT, on the 8th command bit when that command's bit 7 is 1.
- cmd_write: CMD_SHIFT to WRITE_IN, on the 8th command bit when that command's bit 7 is 0.
- status_done: STATUS_OUT to READ_OUT, after 8 status bits.
- frame_end: any state to IDLE, when chip select rises.

Top module: `spi_mem_port`

## Requirements
- R1: After reset, spi_miso_oe, irq, mem_rd and mem_wr are 0 and cmd_reg is 0x00.
- R2: The frame is sent MSB first. Bits 0-15 carry the address and bits 16-23 carry the command. Command bit 7 = 1 selects a read and bit 7 = 0 selects a write.
- R3: On a read, bits 24-31 shift out status_in, MSB first. The byte at ADDR follows from bit 32, then the byte at ADDR+1 from bit 40, and so on.
- R4: On a write, each complete data byte produces one single-cycle mem_wr strobe. The first byte goes to ADDR and each later byte to the next address.
- R5: spi_miso_oe is 0 during the address and command bits and for the whole of a write. It is 1 while status or read data is shifted.
- R6: When chip select rises after a complete command whose low seven bits are not all zero, cmd_reg takes the command and irq is high for exactly one cycle.
- R7: Commands 0x80 and 0x00 leave cmd_reg unchanged and raise no irq.
- R8: A partial write byte cut off by chip select rising produces no mem_wr strobe. Earlier complete bytes are still written, and the interrupt still follows R6.
- R9: A frame aborted before the command byte completes produces no cmd_reg update, no irq and no memory write.
- R10: spi_mosi is sampled on rising spi_sck edges. spi_miso changes only after falling spi_sck edges (mode 0).
- R11: The burst address is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R12: On a read, mem_rd is strobed once when the command's last bit arrives. It is strobed again each time a byte is loaded for output, including one prefetch on the falling edge that follows the final bit. A burst of N data bytes therefore produces N+2 strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad driver |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe; data expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| status_in | input | 8 | Status byte sent at the start of a read |
| cmd_reg | output | 8 | Last accepted command |
| irq | output | 1 | One-cycle interrupt at the end of a frame |

## Verification
The bench aims at the reserved commands 0x80 and 0x00. A design that tested only bit 7 or the whole byte would raise irq or overwrite cmd_reg on those commands. Bursts that cross 0xFFFF catch an address counter narrower than 16 bits, which would write or read the wrong bytes. A write cut off mid-byte catches a design that flushes partial data, which would show up as an extra mem_wr and a corrupted neighbour byte. A frame aborted inside the command catches a design that latches a half-received command. Read bursts check that the status byte comes first and that the output enable stays low through the first 24 bits, where a wrong design would drive the line early or shift the data one byte off.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    typedef enum logic [2:0] {
        IDLE,
        ADDR_SHIFT,
        CMD_SHIFT,
        STATUS_OUT,
        READ_OUT,
        WRITE_IN
    } phase_t;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_end,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              frame_end,
    output logic              frame_ok,
    output logic [DATA_W-1:0] cmd_q
);
    localparam int CNT_W = $clog2(ADDR_W);

    phase_t            st, st_nx;
    logic [CNT_W-1:0]  bcnt;
    logic [DATA_W-1:0] shin, shout, rbuf;
    logic [ADDR_W-1:0] addr;
    logic              cmd_ok, rd_q1, oe_q;

    wire addr_last = (bcnt == CNT_W'(ADDR_W - 1));
    wire byte_last = (bcnt == CNT_W'(DATA_W - 1));
    wire [DATA_W-1:0] shin_nx = {shin[DATA_W-2:0], mosi};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        if (cs_end) begin
            st_nx = IDLE;                                   // frame_end
        end else begin
            unique case (st)
                IDLE:       if (cs_act) st_nx = ADDR_SHIFT; // start
                ADDR_SHIFT: if (sck_rise && addr_last) st_nx = CMD_SHIFT;
                CMD_SHIFT:  if (sck_rise && byte_last)
                                st_nx = shin[DATA_W-2] ? STATUS_OUT : WRITE_IN;
                STATUS_OUT: if (sck_rise && byte_last) st_nx = READ_OUT;
                READ_OUT:   st_nx = READ_OUT;
                WRITE_IN:   st_nx = WRITE_IN;
                default:    st_nx = IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt      <= '0;
            shin      <= '0;
            shout     <= '0;
            rbuf      <= '0;
            addr      <= '0;
            cmd_q     <= '0;
            cmd_ok    <= 1'b0;
            rd_q1     <= 1'b0;
            oe_q      <= 1'b0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_wdata <= '0;
            frame_end <= 1'b0;
            frame_ok  <= 1'b0;
        end else begin
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            frame_end <= 1'b0;
            rd_q1     <= mem_rd;
            if (rd_q1)  rbuf <= mem_rdata;
            if (mem_wr) addr <= addr + 1'b1;
            if (cs_end) begin
                bcnt      <= '0;
                oe_q      <= 1'b0;
                frame_end <= 1'b1;
                frame_ok  <= cmd_ok;
                cmd_ok    <= 1'b0;
            end else begin
                unique case (st)
                    IDLE: begin
                        bcnt   <= '0;
                        cmd_ok <= 1'b0;
                        oe_q   <= 1'b0;
                    end
                    ADDR_SHIFT: if (sck_rise) begin
                        addr <= {addr[ADDR_W-2:0], mosi};
                        bcnt <= addr_last ? '0 : bcnt + 1'b1;
                    end
                    CMD_SHIFT: if (sck_rise) begin
                        shin <= shin_nx;
                        if (byte_last) begin
                            bcnt   <= '0;
                            cmd_q  <= shin_nx;
                            cmd_ok <= 1'b1;
                            mem_rd <= shin[DATA_W-2];
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    STATUS_OUT, READ_OUT: begin
                        if (sck_fall) begin
                            if (bcnt == '0) begin
                                oe_q <= 1'b1;
                                if (st == STATUS_OUT) begin
                                    shout <= status_in;
                                end else begin
                                    shout  <= rbuf;
                                    addr   <= addr + 1'b1;
                                    mem_rd <= 1'b1;
                                end
                            end else begin
                                shout <= {shout[DATA_W-2:0], 1'b0};
                            end
                        end
                        if (sck_rise) bcnt <= byte_last ? '0 : bcnt + 1'b1;
                    end
                    WRITE_IN: if (sck_rise) begin
                        shin <= shin_nx;
                        if (byte_last) begin
                            bcnt      <= '0;
                            mem_wr    <= 1'b1;
                            mem_wdata <= shin_nx;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    default: bcnt <= '0;
                endcase
            end
        end
    end

    assign miso     = shout[DATA_W-1];
    assign miso_oe  = oe_q;
    assign mem_addr = addr;
endmodule

// File: rtl/spi_mem_cmdreg.sv
module spi_mem_cmdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              frame_ok,
    input  logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] cmd_reg,
    output logic              irq
);
    wire reserved = (cmd_q[DATA_W-2:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_reg <= '0;
            irq     <= 1'b0;
        end else if (frame_end && frame_ok && !reserved) begin
            cmd_reg <= cmd_q;
            irq     <= 1'b1;
        end else begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] cmd_reg,
    output logic              irq
);
    logic sck_s, csn_s, mosi_s, sck_d, csn_d;
    logic frame_end, frame_ok;
    logic [DATA_W-1:0] cmd_q;

    spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sck (
        .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
    spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_csn (
        .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));
    spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    spi_mem_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
        .clk(clk), .rst_n(rst_n),
        .cs_act(~csn_s), .cs_end(csn_s & ~csn_d),
        .sck_rise(sck_s & ~sck_d), .sck_fall(~sck_s & sck_d),
        .mosi(mosi_s), .status_in(status_in), .mem_rdata(mem_rdata),
        .miso(spi_miso), .miso_oe(spi_miso_oe),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata),
        .frame_end(frame_end), .frame_ok(frame_ok), .cmd_q(cmd_q));

    spi_mem_cmdreg #(.DATA_W(DATA_W)) i_cmdreg (
        .clk(clk), .rst_n(rst_n),
        .frame_end(frame_end), .frame_ok(frame_ok), .cmd_q(cmd_q),
        .cmd_reg(cmd_reg), .irq(irq));
endmodule

// File: rtl/spi_mem_port_chk.sv
module spi_mem_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_sck,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] cmd_reg,
    input logic              irq
);
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    irq_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmd_reg[DATA_W-2:0] != '0));

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(cmd_reg));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R5
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && spi_miso_oe));

    // R12
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && !$stable(spi_miso)) |-> !spi_sck);
endmodule

bind spi_mem_port spi_mem_port_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cmd_reg(cmd_reg), .irq(irq));

// File: tb/test_spi_mem_port.sv
`timescale 1ns/1ps
module test_spi_mem_port;
    localparam int HALF = 6;
    // {addr[31:16], cmd[15:8], len[7:0]}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        32'h0010_05_03,
        32'h0010_81_03,
        32'hFFFE_00_04,
        32'hFFFE_80_04,
        32'h0042_C3_01,
        32'h0100_7F_01
    };

    logic clk = 0, rst_n = 0;
    logic spi_sck = 0, spi_csn = 1, spi_mosi = 0;
    logic spi_miso, spi_miso_oe, mem_rd, mem_wr, irq;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, status_in, cmd_reg;

    logic [7:0] mem  [0:255];
    logic [7:0] emem [0:255];
    logic [7:0] txb  [0:15];
    logic [7:0] rxb  [0:15];
    logic       oelog[0:127];
    int errors = 0, checks = 0;
    int irq_cnt = 0, wr_cnt = 0, rd_cnt = 0;
    logic [7:0] exp_cmd;

    always #2 clk = ~clk;

    spi_mem_port i_spi_mem_port (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .status_in(status_in),
        .cmd_reg(cmd_reg), .irq(irq));

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= 8'(a * 7 + 3);
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            if (irq)    irq_cnt <= irq_cnt + 1;
            if (mem_wr) wr_cnt  <= wr_cnt + 1;
            if (mem_rd) rd_cnt  <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input int nbits);
        spi_csn = 0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = txb[b/8][7 - (b % 8)];
            repeat (HALF) @(negedge clk);
            rxb[b/8][7 - (b % 8)] = spi_miso;
            oelog[b] = spi_miso_oe;
            spi_sck = 1;
            repeat (HALF) @(negedge clk);
            spi_sck = 0;
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [7:0] wgen(input int v, input int k);
        return 8'(v * 37 + k * 11 + 8'h6C);
    endfunction

    initial begin
        int wd;
        wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) emem[a] = 8'(a * 7 + 3);
        status_in = 8'h00;
        exp_cmd = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(spi_miso_oe == 0 && irq == 0 && mem_rd == 0 && mem_wr == 0,
              "R1 outputs idle", {spi_miso_oe, irq, mem_rd, mem_wr}, 0);
        check(cmd_reg == 8'h00, "R1 cmd_reg", cmd_reg, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        // table walk: R2 R3 R4 R5 R6 R7 R11 R12
        for (int v = 0; v < NV; v++) begin
            logic [15:0] a;
            logic [7:0]  c;
            int          n, irq0, wr0, rd0;
            logic        oe_bad, oe_on;
            a = VEC[v][31:16];
            c = VEC[v][15:8];
            n = int'(VEC[v][7:0]);
            status_in = 8'hA5 ^ 8'(v);
            txb[0] = a[15:8];
            txb[1] = a[7:0];
            txb[2] = c;
            for (int k = 0; k < 12; k++) txb[3 + k] = c[7] ? 8'h00 : wgen(v, k);
            irq0 = irq_cnt; wr0 = wr_cnt; rd0 = rd_cnt;
            spi_frame(c[7] ? 32 + 8 * n : 24 + 8 * n);
            oe_bad = 0; oe_on = 1;
            for (int b = 0; b < 24; b++) if (oelog[b]) oe_bad = 1;
            if (c[7]) begin
                for (int b = 24; b < 32 + 8 * n; b++) if (!oelog[b]) oe_on = 0;
                check(oe_on, "R5 oe during read shift", oe_on, 1);
                check(rxb[3] == status_in, "R3 status byte", rxb[3], status_in);
                for (int k = 0; k < n; k++) begin
                    logic [7:0] ex;
                    ex = emem[8'(a + 16'(k))];
                    check(rxb[4 + k] == ex, "R3/R10/R11 read data", rxb[4 + k], ex);
                end
                check(rd_cnt - rd0 == n + 2, "R12 read strobes", rd_cnt - rd0, n + 2);
            end else begin
                for (int b = 24; b < 24 + 8 * n; b++) if (oelog[b]) oe_bad = 1;
                check(wr_cnt - wr0 == n, "R4 write strobes", wr_cnt - wr0, n);
                for (int k = 0; k < n; k++) begin
                    logic [7:0] ia;
                    ia = 8'(a + 16'(k));
                    emem[ia] = wgen(v, k);
                    check(mem[ia] == emem[ia], "R4/R11 written byte", mem[ia], emem[ia]);
                end
            end
            check(!oe_bad, "R5 oe low in addr/cmd/write", oe_bad, 0);
            if (c[6:0] != 0) exp_cmd = c;
            check(irq_cnt - irq0 == (c[6:0] != 0 ? 1 : 0), "R6/R7 irq count",
                  irq_cnt - irq0, c[6:0] != 0);
            check(cmd_reg == exp_cmd, "R2/R6/R7 cmd_reg", cmd_reg, exp_cmd);
        end

        // R8: one full byte then 5 bits of a second, cut off
        begin
            int irq0, wr0;
            irq0 = irq_cnt; wr0 = wr_cnt;
            txb[0] = 8'h00; txb[1] = 8'h20; txb[2] = 8'h11;
            txb[3] = 8'h3C; txb[4] = 8'hFF;
            spi_frame(24 + 13);
            emem[8'h20] = 8'h3C;
            check(wr_cnt - wr0 == 1, "R8 partial byte dropped", wr_cnt - wr0, 1);
            check(mem[8'h20] == 8'h3C, "R8 full byte kept", mem[8'h20], 8'h3C);
            check(mem[8'h21] == emem[8'h21], "R8 next byte untouched", mem[8'h21], emem[8'h21]);
            exp_cmd = 8'h11;
            check(irq_cnt - irq0 == 1 && cmd_reg == exp_cmd, "R8 irq after partial",
                  cmd_reg, exp_cmd);
        end

        // R9: abort inside the command byte
        begin
            int irq0, wr0;
            irq0 = irq_cnt; wr0 = wr_cnt;
            txb[0] = 8'h00; txb[1] = 8'h30; txb[2] = 8'h22;
            spi_frame(20);
            check(irq_cnt == irq0, "R9 no irq on abort", irq_cnt - irq0, 0);
            check(cmd_reg == exp_cmd, "R9 cmd_reg held", cmd_reg, exp_cmd);
            check(wr_cnt == wr0, "R9 no write on abort", wr_cnt - wr0, 0);
            check(spi_miso_oe == 0, "R5 oe low after abort", spi_miso_oe, 0);
        end

        // R1: reset mid-state returns to idle values
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(cmd_reg == 0 && irq == 0 && spi_miso_oe == 0, "R1 reapplied reset",
              cmd_reg, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule